// File: doc/BRIEF.md
# Strobe-Kicked Watchdog Timer

This block watches a processor's health by waiting for a strobe input to fall from high to low. Each falling edge restarts the timeout. If a full timeout passes without such an edge, the block raises a one-cycle timeout request. A separate reset generator uses that request to drive system reset active.

The block only counts while the reset generator reports reset inactive (`sys_rst` low). While reset is active, everything is held cleared. The period is chosen by a 2-bit select that is captured during reset. Counting starts from the full period on the first clock with reset inactive.

All periods are whole milliseconds. A prescaler divides the clock by `CLK_PER_MS` to make the millisecond tick.

Top module: `strobe_watchdog`

## Requirements
- R1: Select code 00 gives a period of T_SHORT_MS (150) milliseconds, code 01 gives T_MID_MS (600), and code 10 gives T_LONG_MS (1200). One millisecond is CLK_PER_MS clock cycles.
- R2: Select code 11 gives the same period as code 01.
- R3: If clock edge 1 is the first rising edge that samples `sys_rst` low, then `timeout_req` rises after clock edge P, where P is the period in cycles, unless a kick arrives first.
- R4: A high-to-low change of `strobe` that is applied before clock edge a passes a two-flop synchronizer. At edge a+2 it restarts the count from zero, so `timeout_req` rises after edge a+2+P.
- R5: A `strobe` held steadily low or steadily high is not a kick, and a low-to-high change has no effect.
- R6: While `sys_rst` is high, the count is held at zero, strobe edges are ignored, and `timeout_req` stays low.
- R7: `period_sel` is captured while `sys_rst` is high. Changes while the watchdog runs do not alter the running period.
- R8: `timeout_req` is high for exactly one cycle. After it, no further request is raised until `sys_rst` has gone high and then low again.
- R9: While `rst_n` is low, `timeout_req` is low and all state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| sys_rst | input | 1 | Reset-active status from the reset generator; high holds the watchdog idle |
| strobe | input | 1 | Asynchronous kick input; a falling edge restarts the timeout |
| period_sel | input | 2 | Period code: 00 short, 01 and 11 middle, 10 long |
| timeout_req | output | 1 | One-cycle pulse when the period expires |

## Verification
The bench keeps a countdown of negedges until the next pulse is due:
- **Arming:** releasing `sys_rst` loads P.
- **Kick:** driving a strobe fall loads P+3, which covers the two synchronizer flops and the edge register.
- **Reset or a pulse already given:** the countdown is disabled.

Every negedge the bench compares `timeout_req` with "countdown has reached zero". This checks both that the pulse arrives in the exact cycle and that it is absent in all other cycles, including the cycles after a pulse and the cycles during reset. All stimulus changes at negedges, so each input is seen first by the next rising edge.

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int CLK_PER_MS = 50000,
  parameter int T_SHORT_MS = 150,
  parameter int T_MID_MS   = 600,
  parameter int T_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       strobe,
  input  logic [1:0] period_sel,
  output logic       timeout_req
);
  localparam int PW  = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam int MSW = $clog2(T_LONG_MS + 1);
  localparam logic [PW-1:0] PRE_TOP = PW'(CLK_PER_MS - 1);

  logic [2:0]     sync_q;
  logic [PW-1:0]  pre_cnt;
  logic [MSW-1:0] ms_cnt;
  logic [MSW-1:0] lim;
  logic           done;
  logic           kick, run, tick_ms, expire;
  logic [MSW-1:0] sel_ms;

  always_comb begin
    case (period_sel)
      2'b00:   sel_ms = MSW'(T_SHORT_MS);
      2'b10:   sel_ms = MSW'(T_LONG_MS);
      default: sel_ms = MSW'(T_MID_MS);
    endcase
  end

  assign run     = !sys_rst && !done;
  assign kick    = run && sync_q[2] && !sync_q[1];
  assign tick_ms = (pre_cnt == PRE_TOP);
  assign expire  = run && !kick && tick_ms && (ms_cnt == lim - MSW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt     <= '0;
      ms_cnt      <= '0;
      lim         <= MSW'(T_MID_MS);
      done        <= 1'b0;
      timeout_req <= 1'b0;
    end else if (sys_rst) begin
      pre_cnt     <= '0;
      ms_cnt      <= '0;
      lim         <= sel_ms;
      done        <= 1'b0;
      timeout_req <= 1'b0;
    end else begin
      timeout_req <= expire;
      if (expire) done <= 1'b1;
      if (!run || kick || expire) begin
        pre_cnt <= '0;
        ms_cnt  <= '0;
      end else if (tick_ms) begin
        pre_cnt <= '0;
        ms_cnt  <= ms_cnt + MSW'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end
endmodule

module strobe_watchdog_chk #(
  parameter int PW  = 1,
  parameter int MSW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sys_rst,
  input logic           timeout_req,
  input logic           kick,
  input logic           done,
  input logic [PW-1:0]  pre_cnt,
  input logic [MSW-1:0] ms_cnt,
  input logic [MSW-1:0] lim
);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req |=> !timeout_req);
  // R6
  idle_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (!timeout_req && ms_cnt == '0 && pre_cnt == '0));
  // R4
  kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (ms_cnt == '0 && pre_cnt == '0 && !timeout_req));
  // R8
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sys_rst) |=> !timeout_req);
  // R7
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst |=> $stable(lim));
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt < lim);
endmodule

bind strobe_watchdog strobe_watchdog_chk #(.PW(PW), .MSW(MSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .timeout_req(timeout_req),
  .kick(kick), .done(done), .pre_cnt(pre_cnt), .ms_cnt(ms_cnt), .lim(lim)
);

// File: tb/tb_strobe_watchdog.sv
`timescale 1ns/1ps
module tb_strobe_watchdog;
  localparam int CPM = 4;

  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b1, strobe = 1'b1;
  logic [1:0] period_sel = 2'b00;
  logic timeout_req;
  int checks = 0, errors = 0, due = -1, cyc = 0;

  always #2.5 clk = ~clk;

  strobe_watchdog #(.CLK_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .strobe(strobe),
    .period_sel(period_sel), .timeout_req(timeout_req));

  function automatic int period_cycles(input logic [1:0] s);
    case (s)
      2'b00:   return 150 * CPM;
      2'b10:   return 1200 * CPM;
      default: return 600 * CPM;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(input string tag);
    logic e;
    @(negedge clk);
    if (due > 0) due--;
    e = (due == 0);
    check(timeout_req == e, tag, int'(timeout_req), int'(e));
    if (due == 0) due = -1;
  endtask

  task automatic arm(input logic [1:0] s, input string tag);
    sys_rst = 1'b1; strobe = 1'b1; due = -1;
    repeat (2) tick("R6");
    period_sel = s;
    repeat (4) tick("R6");
    sys_rst = 1'b0;
    due = period_cycles(s);
  endtask

  task automatic kick_now(input int hold);
    strobe = 1'b0;
    due = period_cycles(period_sel) + 3;
    repeat (hold) tick("R4");
  endtask

  task automatic run_out(input string tag, input int extra);
    while (due != -1) tick(tag);
    repeat (extra) tick("R8");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired, no end of run");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [1:0] s;
    void'($urandom(32'd7));
    repeat (3) begin
      @(negedge clk);
      check(timeout_req == 1'b0, "R9", int'(timeout_req), 0);
    end
    rst_n = 1'b1;

    // R1 each code, R3 exact expiry from release, R8 no second pulse
    arm(2'b00, "R1"); run_out("R1", 50);
    arm(2'b01, "R1"); run_out("R3", 50);
    arm(2'b10, "R1"); run_out("R1", 50);
    // R2 code 11 behaves as 01
    arm(2'b11, "R2"); run_out("R2", period_cycles(2'b11) + 10);

    // R7 select change while running has no effect
    arm(2'b00, "R7");
    repeat (20) tick("R7");
    period_sel = 2'b10;
    run_out("R7", 20);

    // R5 held low: one kick only; rising edge no effect
    arm(2'b00, "R5");
    repeat (100) tick("R5");
    kick_now(1);
    repeat (period_cycles(2'b00) - 20) tick("R5");
    strobe = 1'b1;
    run_out("R5", 30);

    // R6 reset mid-count aborts; strobe toggles in reset ignored
    arm(2'b00, "R6");
    repeat (200) tick("R6");
    sys_rst = 1'b1; due = -1;
    for (int i = 0; i < period_cycles(2'b00) + 20; i++) begin
      strobe = i[3];
      tick("R6");
    end
    strobe = 1'b1;
    repeat (5) tick("R6");
    sys_rst = 1'b0;
    due = period_cycles(2'b00);
    run_out("R6", 20);

    // R4 random kicks, R3 expiry after last kick
    for (int t = 0; t < 6; t++) begin
      s = 2'($urandom % 4);
      arm(s, "R4");
      n = period_cycles(s);
      for (int k = 0; k < int'($urandom % 4); k++) begin
        repeat (4 + ($urandom % (n - 8))) tick("R4");
        kick_now(1 + ($urandom % 3));
        strobe = 1'b1;
      end
      run_out("R4", 20);
    end

    // R9 chip reset clears state mid-count
    arm(2'b00, "R9");
    repeat (300) tick("R9");
    rst_n = 1'b0; due = -1;
    repeat (3) tick("R9");
    rst_n = 1'b1;
    due = period_cycles(2'b01);
    run_out("R9", 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule